// File: doc/BRIEF.md
# Memory-Card Command and Response Register Front End

This block sits between a word-addressed register bus and the card-side logic of an SD-style memory card controller. Software programs a clock divider, a channel enable mask and a start mask. It pushes a command one byte at a time through a single command port, and drains the card's reply one byte at a time through the same port. Block data moves through a second port, one 32-bit word per access, which the block splits into four card bytes or assembles from four card bytes.

Six command bytes make one frame. The sixth byte hands the frame to the card side as a 6-bit index, a 32-bit argument and a check byte, over a valid/ready handshake. The bus access that wrote the sixth byte completes only after the card has returned its response. Card replies come back in fixed layouts. A long 16-byte reply gains a 0x3F marker byte in front. A short 4-byte reply is framed by its command index and a zero trailer byte. After a reset command (index 0) the next command-port write is swallowed, because on the wire it only provides dummy clocks. While no card is present, the command and data ports return all ones and ignore writes.

Top module: `mcard_regfront`

## Requirements
- R1: After reset, the divider, enable, start and pending registers read 0, and the configuration outputs are 0. The response length is 0 and the response read position is 0, so the first command-port read returns 0x00 and raises the overrun flag.
- R2: Word offsets 0, 1 and 3 (divider, enable, start) store and return all 32 bits written. `clkdiv_o` mirrors the divider, `enable_o` mirrors enable bits 3:0 and `start_o` mirrors start bits 1:0. Every access is acknowledged by a single-cycle `bus_ack`.
- R3: Offset 2 (pending) reads bit 1 equal to enable bit 1 (command receive) and bit 3 equal to enable bit 3 (data receive). All other bits read 0. Writing ones to pending does not clear a receive bit whose enable bit is still set.
- R4: A write to offset 4 stores `bus_wdata[7:0]` as the next frame byte. On the sixth byte the frame is presented: `cmd_index` = byte0[5:0], `cmd_arg` = bytes 1..4 with byte 1 in bits 31:24, and `cmd_crc` = byte 5. The values are held stable until `cmd_ready`.
- R5: After a frame with index 0 has been issued, the next write to offset 4 is discarded and does not advance the frame position. The following six writes form the next frame.
- R6: Response layouts, with `rsp_data[127:120]` as the first card byte:
  - Card length 4: index, the 4 card bytes, then 0x00, for 6 bytes.
  - Card length 16: 0x3F, then the 16 card bytes, for 17 bytes.
  - Card length 0: the index alone, for length 0.
- R7: Each offset-4 read returns the buffer byte at the read position and advances it. Positions at or beyond the response length read 0x00. When the advanced position exceeds the length, it returns to 0 and `rsp_overrun` pulses together with that read's `bus_ack`.
- R8: While `card_present` is low, offset-4 reads return 0x000000FF and offset-5 reads return 0xFFFFFFFF. Writes to offsets 4 and 5 cause no card traffic and leave the frame position, discard flag and read position unchanged.
- R9: A write to offset 5 sends four bytes on `dat_wr_byte`, bits 31:24 first, each taken on `dat_wr_valid` and `dat_wr_ready`.
- R10: A read of offset 5 collects four bytes on `dat_rd_byte`. The first byte lands in bits 31:24.
- R11: Reads of offsets above 5 return 0. Writes there change no register.
- R12: No `bus_ack` is given while `cmd_valid` is high. The sixth-byte write is acknowledged only after `rsp_valid` has been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until `bus_ack` |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| bus_ack | output | 1 | Single-cycle access completion |
| rsp_overrun | output | 1 | Read position wrapped on this command-port read |
| card_present | input | 1 | Card inserted |
| clkdiv_o | output | 32 | Divider register |
| enable_o | output | 4 | Enable bits 3:0 |
| start_o | output | 2 | Start bits 1:0 |
| cmd_valid | output | 1 | Frame presented to card side |
| cmd_ready | input | 1 | Card side took the frame |
| cmd_index | output | 6 | Command index |
| cmd_arg | output | 32 | Command argument |
| cmd_crc | output | 8 | Check byte passed through |
| rsp_valid | input | 1 | Response strobe |
| rsp_len | input | 5 | Card response length: 0, 4 or 16 |
| rsp_data | input | 128 | Card response bytes, first in bits 127:120 |
| dat_wr_valid | output | 1 | Outgoing data byte valid |
| dat_wr_ready | input | 1 | Card side took the byte |
| dat_wr_byte | output | 8 | Outgoing data byte |
| dat_rd_ready | output | 1 | Block wants an incoming data byte |
| dat_rd_valid | input | 1 | Incoming data byte valid |
| dat_rd_byte | input | 8 | Incoming data byte |

## Verification
Most internal faults in this block surface on the command port, where they are easy to see. A frame position that is off by one shifts every byte of `cmd_arg`, or fires `cmd_valid` a write early or late. A stuck discard flag loses or keeps the first byte after a reset command. These show up at the very next frame hand-off. A wrong response length or a wrong read position shows up within one command-port read: the returned byte is wrong, or the overrun pulse comes a read early or late. The bench tracks every byte software would see and compares them one by one. Pending and configuration faults are visible immediately: pending on the next read of offset 2, and the configuration outputs on every clock.

// File: rtl/mcard_regfront.sv
module mcard_regfront #(
  parameter int ADDR_W  = 4,
  parameter int RSP_MAX = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_req,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_ack,
  output logic                 rsp_overrun,
  input  logic                 card_present,
  output logic [31:0]          clkdiv_o,
  output logic [3:0]           enable_o,
  output logic [1:0]           start_o,
  output logic                 cmd_valid,
  input  logic                 cmd_ready,
  output logic [5:0]           cmd_index,
  output logic [31:0]          cmd_arg,
  output logic [7:0]           cmd_crc,
  input  logic                 rsp_valid,
  input  logic [$clog2(RSP_MAX+1)-1:0] rsp_len,
  input  logic [RSP_MAX*8-1:0] rsp_data,
  output logic                 dat_wr_valid,
  input  logic                 dat_wr_ready,
  output logic [7:0]           dat_wr_byte,
  output logic                 dat_rd_ready,
  input  logic                 dat_rd_valid,
  input  logic [7:0]           dat_rd_byte
);
  localparam int FRAME_N = 6;
  localparam int BUF_N   = RSP_MAX + 2;
  localparam int PTR_W   = $clog2(BUF_N + 1);
  localparam int FPTR_W  = $clog2(FRAME_N);
  localparam int LEN_W   = $clog2(RSP_MAX + 1);
  localparam int SHORT_N = 4;

  localparam logic [ADDR_W-1:0] A_DIV   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN    = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMD   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_DAT   = ADDR_W'(5);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_RSP, S_DWR, S_DRD} st_t;

  st_t               st_q;
  logic [31:0]       div_q, en_q, start_q, word_q, rdata_q;
  logic [7:0]        frame_q [FRAME_N];
  logic [7:0]        rbuf_q  [BUF_N];
  logic [FPTR_W-1:0] fptr_q;
  logic [PTR_W-1:0]  rlen_q, rptr_q;
  logic [1:0]        bcnt_q;
  logic              skip_q, ack_q, ovr_q;

  wire take = bus_req && !ack_q && (st_q == S_IDLE);
  wire [31:0] pend = {28'b0, en_q[3], 1'b0, en_q[1], 1'b0};
  wire [PTR_W-1:0] rptr_nx = rptr_q + PTR_W'(1);

  assign bus_rdata    = rdata_q;
  assign bus_ack      = ack_q;
  assign rsp_overrun  = ovr_q;
  assign clkdiv_o     = div_q;
  assign enable_o     = en_q[3:0];
  assign start_o      = start_q[1:0];
  assign cmd_valid    = (st_q == S_CMD);
  assign cmd_index    = frame_q[0][5:0];
  assign cmd_arg      = {frame_q[1], frame_q[2], frame_q[3], frame_q[4]};
  assign cmd_crc      = frame_q[5];
  assign dat_wr_valid = (st_q == S_DWR);
  assign dat_wr_byte  = word_q[31:24];
  assign dat_rd_ready = (st_q == S_DRD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      div_q   <= '0;
      en_q    <= '0;
      start_q <= '0;
      word_q  <= '0;
      rdata_q <= '0;
      fptr_q  <= '0;
      rlen_q  <= '0;
      rptr_q  <= '0;
      bcnt_q  <= '0;
      skip_q  <= 1'b0;
      ack_q   <= 1'b0;
      ovr_q   <= 1'b0;
      for (int i = 0; i < FRAME_N; i++) frame_q[i] <= '0;
      for (int i = 0; i < BUF_N; i++)   rbuf_q[i]  <= '0;
    end else begin
      ack_q <= 1'b0;
      ovr_q <= 1'b0;
      unique case (st_q)
        S_IDLE: if (take) begin
          rdata_q <= '0;
          ack_q   <= 1'b1;
          if (bus_we) begin
            unique case (bus_addr)
              A_DIV:   div_q   <= bus_wdata;
              A_EN:    en_q    <= bus_wdata;
              A_START: start_q <= bus_wdata;
              A_CMD: if (card_present) begin
                if (skip_q) begin
                  skip_q <= 1'b0;
                end else begin
                  frame_q[fptr_q] <= bus_wdata[7:0];
                  if (fptr_q == FPTR_W'(FRAME_N - 1)) begin
                    fptr_q <= '0;
                    ack_q  <= 1'b0;
                    st_q   <= S_CMD;
                  end else begin
                    fptr_q <= fptr_q + FPTR_W'(1);
                  end
                end
              end
              A_DAT: if (card_present) begin
                word_q <= bus_wdata;
                bcnt_q <= '0;
                ack_q  <= 1'b0;
                st_q   <= S_DWR;
              end
              default: ;
            endcase
          end else begin
            unique case (bus_addr)
              A_DIV:   rdata_q <= div_q;
              A_EN:    rdata_q <= en_q;
              A_PEND:  rdata_q <= pend;
              A_START: rdata_q <= start_q;
              A_CMD: if (!card_present) begin
                rdata_q <= 32'h0000_00FF;
              end else begin
                rdata_q <= {24'b0, rbuf_q[rptr_q]};
                if (rptr_nx > rlen_q) begin
                  rptr_q <= '0;
                  ovr_q  <= 1'b1;
                end else begin
                  rptr_q <= rptr_nx;
                end
              end
              A_DAT: if (!card_present) begin
                rdata_q <= 32'hFFFF_FFFF;
              end else begin
                bcnt_q <= '0;
                ack_q  <= 1'b0;
                st_q   <= S_DRD;
              end
              default: ;
            endcase
          end
        end
        S_CMD: if (cmd_ready) st_q <= S_RSP;
        S_RSP: if (rsp_valid) begin
          rbuf_q[0] <= (rsp_len == LEN_W'(RSP_MAX)) ? 8'h3F : {2'b0, frame_q[0][5:0]};
          for (int k = 1; k <= RSP_MAX; k++)
            rbuf_q[k] <= (LEN_W'(k - 1) < rsp_len) ? rsp_data[(RSP_MAX-k)*8 +: 8] : 8'h00;
          rbuf_q[BUF_N-1] <= 8'h00;
          if (rsp_len == LEN_W'(RSP_MAX))      rlen_q <= PTR_W'(RSP_MAX + 1);
          else if (rsp_len == LEN_W'(SHORT_N)) rlen_q <= PTR_W'(SHORT_N + 2);
          else                                 rlen_q <= PTR_W'(rsp_len);
          rptr_q <= '0;
          skip_q <= (frame_q[0][5:0] == 6'd0);
          ack_q  <= 1'b1;
          st_q   <= S_IDLE;
        end
        S_DWR: if (dat_wr_ready) begin
          word_q <= {word_q[23:0], 8'h00};
          bcnt_q <= bcnt_q + 2'd1;
          if (bcnt_q == 2'd3) begin
            ack_q <= 1'b1;
            st_q  <= S_IDLE;
          end
        end
        S_DRD: if (dat_rd_valid) begin
          word_q <= {word_q[23:0], dat_rd_byte};
          bcnt_q <= bcnt_q + 2'd1;
          if (bcnt_q == 2'd3) begin
            rdata_q <= {word_q[23:0], dat_rd_byte};
            ack_q   <= 1'b1;
            st_q    <= S_IDLE;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcard_regfront_chk.sv
module mcard_regfront_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_ack,
  input logic              rsp_overrun,
  input logic              card_present,
  input logic [3:0]        enable_o,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [5:0]        cmd_index,
  input logic [31:0]       cmd_arg,
  input logic [7:0]        cmd_crc,
  input logic              dat_wr_valid,
  input logic              dat_wr_ready,
  input logic [7:0]        dat_wr_byte
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |=> !bus_ack);

  p_pend_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack && bus_req && !bus_we && bus_addr == ADDR_W'(2) |->
      bus_rdata == {28'b0, enable_o[3], 1'b0, enable_o[1], 1'b0});

  p_frame_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_index) && $stable(cmd_arg) && $stable(cmd_crc));

  p_overrun_on_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_overrun |-> bus_ack && !bus_we && bus_addr == ADDR_W'(4));

  p_no_issue_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_valid) || $rose(dat_wr_valid) |-> card_present);

  p_byte_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dat_wr_valid && !dat_wr_ready |=> dat_wr_valid && $stable(dat_wr_byte));

  p_high_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack && bus_req && !bus_we && bus_addr > ADDR_W'(5) |-> bus_rdata == 32'h0);

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !bus_ack);
endmodule

bind mcard_regfront mcard_regfront_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .bus_ack(bus_ack), .rsp_overrun(rsp_overrun),
  .card_present(card_present), .enable_o(enable_o), .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg), .cmd_crc(cmd_crc),
  .dat_wr_valid(dat_wr_valid), .dat_wr_ready(dat_wr_ready), .dat_wr_byte(dat_wr_byte)
);

// File: tb/tb_mcard_regfront.sv
module tb_mcard_regfront;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b0;
  logic         bus_req = 1'b0, bus_we = 1'b0;
  logic [3:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_ack, rsp_overrun;
  logic         card_present = 1'b1;
  logic [31:0]  clkdiv_o;
  logic [3:0]   enable_o;
  logic [1:0]   start_o;
  logic         cmd_valid, cmd_ready = 1'b0;
  logic [5:0]   cmd_index;
  logic [31:0]  cmd_arg;
  logic [7:0]   cmd_crc;
  logic         rsp_valid = 1'b0;
  logic [4:0]   rsp_len = '0;
  logic [127:0] rsp_data = '0;
  logic         dat_wr_valid, dat_wr_ready = 1'b0;
  logic [7:0]   dat_wr_byte;
  logic         dat_rd_ready, dat_rd_valid = 1'b0;
  logic [7:0]   dat_rd_byte = '0;

  mcard_regfront dut (.*);

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // card-side model state
  int   rsp_delay = 3, rsp_wait = 0;
  bit   rsp_pend = 0, rsp_seen = 0;
  int   card_len = 4;
  logic [7:0] card_bytes [16];
  int   frames = 0;
  logic [5:0]  got_idx;
  logic [31:0] got_arg;
  logic [7:0]  got_crc;
  logic [7:0]  wr_q [$];
  logic [7:0]  rd_q [$];
  bit   tog = 0;

  // behavioural model of software-visible state
  logic [31:0] m_div = 0, m_en = 0, m_start = 0;
  logic [7:0]  m_frame [$];
  logic [7:0]  m_rsp [$];
  int          m_len = 0, m_ptr = 0;
  bit          m_skip = 0;

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cmd_valid && cmd_ready) begin
      frames++; got_idx = cmd_index; got_arg = cmd_arg; got_crc = cmd_crc;
    end
    if (rsp_valid) rsp_seen = 1;
    if (dat_wr_valid && dat_wr_ready) wr_q.push_back(dat_wr_byte);
    if (dat_rd_ready && dat_rd_valid) void'(rd_q.pop_front());
  end

  always @(negedge clk) begin
    tog = ~tog;
    rsp_valid = 1'b0;
    if (cmd_valid && !cmd_ready) begin
      cmd_ready = 1'b1; rsp_pend = 1; rsp_wait = rsp_delay;
    end else begin
      cmd_ready = 1'b0;
      if (rsp_pend) begin
        if (rsp_wait == 0) begin
          rsp_pend = 0; rsp_valid = 1'b1; rsp_len = 5'(card_len);
          for (int i = 0; i < 16; i++) rsp_data[(15-i)*8 +: 8] = card_bytes[i];
        end else rsp_wait--;
      end
    end
    dat_wr_ready = tog;
    dat_rd_valid = dat_rd_ready && tog && rd_q.size() > 0;
    dat_rd_byte  = rd_q.size() > 0 ? rd_q[0] : 8'h00;
    if (rst_n && !done) begin
      chk(clkdiv_o == m_div, "R2 clkdiv_o", clkdiv_o, m_div);
      chk(enable_o == m_en[3:0], "R2 enable_o", {28'b0, enable_o}, m_en);
      chk(start_o == m_start[1:0], "R2 start_o", {30'b0, start_o}, m_start);
    end
  end

  always @(posedge clk) if (cyc > 100000 && !done) begin
    done = 1; fails++; tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic bus(input bit we, input int addr, input logic [31:0] wd,
                     output logic [31:0] rd, output bit ovr, output int waited);
    @(negedge clk);
    bus_req = 1; bus_we = we; bus_addr = 4'(addr); bus_wdata = wd; waited = 0;
    do begin @(negedge clk); waited++; end while (!bus_ack);
    rd = bus_rdata; ovr = rsp_overrun; bus_req = 0;
  endtask

  task automatic wr(input int addr, input logic [31:0] wd);
    logic [31:0] rd; bit ovr; int w;
    bus(1, addr, wd, rd, ovr, w);
    if (addr == 0) m_div = wd;
    if (addr == 1) m_en = wd;
    if (addr == 3) m_start = wd;
  endtask

  task automatic rd_reg(input int addr, input logic [31:0] exp, input string tag);
    logic [31:0] rd; bit ovr; int w;
    bus(0, addr, 0, rd, ovr, w);
    chk(rd == exp, tag, rd, exp);
  endtask

  task automatic cmd_wr(input logic [31:0] wd);
    logic [31:0] rd; bit ovr; int w; int f0;
    f0 = frames; rsp_seen = 0;
    bus(1, 4, wd, rd, ovr, w);
    if (!card_present) begin
      chk(frames == f0, "R8 no frame when absent", frames, f0);
      return;
    end
    if (m_skip) begin
      m_skip = 0;
      chk(frames == f0, "R5 discarded write", frames, f0);
      return;
    end
    m_frame.push_back(wd[7:0]);
    if (m_frame.size() < 6) begin
      chk(frames == f0, "R4 no early issue", frames, f0);
      return;
    end
    chk(frames == f0 + 1, "R4 frame issued", frames, f0 + 1);
    chk(got_idx == m_frame[0][5:0], "R4 index", {26'b0, got_idx}, {26'b0, m_frame[0][5:0]});
    chk(got_arg == {m_frame[1], m_frame[2], m_frame[3], m_frame[4]}, "R4 arg",
        got_arg, {m_frame[1], m_frame[2], m_frame[3], m_frame[4]});
    chk(got_crc == m_frame[5], "R4 crc", {24'b0, got_crc}, {24'b0, m_frame[5]});
    chk(rsp_seen && w >= rsp_delay + 2, "R12 ack after response", w, rsp_delay + 2);
    m_rsp.delete();
    if (card_len == 16) begin
      m_rsp.push_back(8'h3F);
      for (int i = 0; i < 16; i++) m_rsp.push_back(card_bytes[i]);
      m_len = 17;
    end else if (card_len == 4) begin
      m_rsp.push_back({2'b0, m_frame[0][5:0]});
      for (int i = 0; i < 4; i++) m_rsp.push_back(card_bytes[i]);
      m_rsp.push_back(8'h00);
      m_len = 6;
    end else begin
      m_rsp.push_back({2'b0, m_frame[0][5:0]});
      m_len = 0;
    end
    m_ptr = 0;
    m_skip = (m_frame[0][5:0] == 0);
    m_frame.delete();
  endtask

  task automatic cmd_rd(input string tag);
    logic [31:0] rd, exp; bit ovr, eovr; int w;
    bus(0, 4, 0, rd, ovr, w);
    if (!card_present) begin
      chk(rd == 32'hFF, "R8 cmd read absent", rd, 32'hFF);
      return;
    end
    exp = (m_ptr < m_rsp.size()) ? {24'b0, m_rsp[m_ptr]} : 32'h0;
    m_ptr++;
    eovr = m_ptr > m_len;
    if (eovr) m_ptr = 0;
    chk(rd == exp, tag, rd, exp);
    chk(ovr == eovr, "R7 overrun flag", {31'b0, ovr}, {31'b0, eovr});
  endtask

  task automatic frame6(input logic [7:0] b0, input logic [31:0] arg, input logic [7:0] crc);
    cmd_wr({24'hA5A5A5, b0});
    cmd_wr({24'h5A5A5A, arg[31:24]});
    cmd_wr({24'hFFFFFF, arg[23:16]});
    cmd_wr({24'h123456, arg[15:8]});
    cmd_wr({24'h000000, arg[7:0]});
    cmd_wr({24'hC3C3C3, crc});
  endtask

  initial begin
    logic [31:0] rd; bit ovr; int w;
    for (int i = 0; i < 16; i++) card_bytes[i] = 8'(8'h10 + i * 7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_reg(0, 0, "R1 divider reset");
    rd_reg(1, 0, "R1 enable reset");
    rd_reg(2, 0, "R1 pending reset");
    rd_reg(3, 0, "R1 start reset");
    cmd_rd("R1 first command read");
    // R2 storage
    wr(0, 32'hDEAD_0F0F); rd_reg(0, 32'hDEAD_0F0F, "R2 divider");
    wr(3, 32'hFFFF_FFFE); rd_reg(3, 32'hFFFF_FFFE, "R2 start");
    wr(1, 32'h8000_0005); rd_reg(1, 32'h8000_0005, "R2 enable");
    // R3 pending
    rd_reg(2, 32'h0, "R3 pending tx only");
    wr(1, 32'hF); rd_reg(2, 32'hA, "R3 pending rx");
    wr(2, 32'hF); rd_reg(2, 32'hA, "R3 pending reasserts");
    wr(1, 32'h8); rd_reg(2, 32'h8, "R3 pending data rx");
    wr(1, 32'h0); rd_reg(2, 32'h0, "R3 pending cleared by enable");
    // R4/R6/R7 short response
    card_len = 4; rsp_delay = 3;
    frame6(8'hD1, 32'h0102_0304, 8'h95);
    for (int i = 0; i < 8; i++) cmd_rd("R6 short response byte");
    // R6/R7 long response, long wait (R12)
    card_len = 16; rsp_delay = 9;
    frame6(8'h02, 32'hCAFE_BABE, 8'h4D);
    for (int i = 0; i < 19; i++) cmd_rd("R6 long response byte");
    // R5 reset command then discarded byte
    card_len = 0; rsp_delay = 1;
    frame6(8'h40, 32'h0, 8'h95);
    cmd_rd("R6 empty response index");
    cmd_rd("R7 wrap after empty");
    cmd_wr(32'h0000_00FF);
    card_len = 4;
    frame6(8'h08, 32'h0000_01AA, 8'h87);
    cmd_rd("R5 frame after discard");
    // R8 card absent mid-frame
    cmd_wr(32'h37); cmd_wr(32'h00); cmd_wr(32'h00);
    card_present = 0;
    cmd_wr(32'h99); cmd_wr(32'h98);
    cmd_rd("R8 cmd read absent");
    bus(0, 5, 0, rd, ovr, w);
    chk(rd == 32'hFFFF_FFFF, "R8 data read absent", rd, 32'hFFFF_FFFF);
    bus(1, 5, 32'h1234_5678, rd, ovr, w);
    chk(wr_q.size() == 0, "R8 data write ignored", wr_q.size(), 0);
    card_present = 1;
    cmd_wr(32'h00); cmd_wr(32'h00); cmd_wr(32'h77);
    cmd_rd("R8 response after absent period");
    // R9 data write
    wr_q.delete();
    bus(1, 5, 32'hA1B2_C3D4, rd, ovr, w);
    chk(wr_q.size() == 4, "R9 byte count", wr_q.size(), 4);
    if (wr_q.size() == 4)
      chk({wr_q[0], wr_q[1], wr_q[2], wr_q[3]} == 32'hA1B2_C3D4, "R9 byte order",
          {wr_q[0], wr_q[1], wr_q[2], wr_q[3]}, 32'hA1B2_C3D4);
    // R10 data read
    rd_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    bus(0, 5, 0, rd, ovr, w);
    chk(rd == 32'h1122_3344, "R10 packed word", rd, 32'h1122_3344);
    rd_q = '{8'hF0, 8'h0F, 8'h80, 8'h01};
    bus(0, 5, 0, rd, ovr, w);
    chk(rd == 32'hF00F_8001, "R10 packed word 2", rd, 32'hF00F_8001);
    // R11 offsets above 5
    bus(1, 6, 32'hFFFF_FFFF, rd, ovr, w);
    bus(1, 15, 32'hFFFF_FFFF, rd, ovr, w);
    rd_reg(6, 0, "R11 offset 6 reads zero");
    rd_reg(15, 0, "R11 offset 15 reads zero");
    rd_reg(0, m_div, "R11 divider untouched");
    rd_reg(1, m_en, "R11 enable untouched");
    rd_reg(3, m_start, "R11 start untouched");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule